// File: doc/BRIEF.md
# Dual-Clock FIFO with Offset Flags

This block is a first-in first-out buffer of 64 words by 36 bits that sits between two clock domains. Words are written on the write clock and read on the read clock; the two clocks may be unrelated or the same. Each side sees only flags that are timed to its own clock. Both sides have an active-low empty or full flag and an active-low almost-empty or almost-full flag.

Each port moves a word on a rising clock edge only while its active-low chip select is low and its enable is high. A write is blocked while the full flag is low, and a read is blocked while the empty flag is low. A blocked attempt changes no pointer and no stored word.

The threshold X for the almost flags comes from a two-bit select input. The select is sampled on the rising edge of the reset input. Pointers cross between the domains in Gray code through two-flop synchronizers. Because of this, a flag that is being released follows the event that released it by two edges of the clock that samples it.

Top module: `dcf_fifo`

## Requirements
- R1: Words are read out in the same order they were written, with all 36 bits intact. The buffer holds up to 64 words.
- R2: While `rst_ni` is low, `full_no`, `empty_no` and `almost_empty_no` are low and `rd_data_o` is zero.
- R3: `full_no` goes high on the second rising edge of `wclk_i` after `rst_ni` rises.
- R4: `empty_no` goes high on the second rising edge of `rclk_i` after a word is written into an empty buffer. It goes low right after the read edge that removes the last word.
- R5: A write happens on a rising `wclk_i` edge only when `wr_cs_ni` is 0, `wr_en_i` is 1 and `full_no` is 1. Any other attempt leaves the contents unchanged.
- R6: A read happens on a rising `rclk_i` edge only when `rd_cs_ni` is 0, `rd_en_i` is 1 and `empty_no` is 1. When no read happens, `rd_data_o` holds its value.
- R7: `full_no` is low while the write side counts 64 stored words. A read frees a slot for writing two `wclk_i` edges after the read edge.
- R8: `almost_empty_no` is low when the word count seen by the read side is less than or equal to X.
- R9: `almost_full_no` is low when the free-slot count seen by the write side is less than or equal to X. It is high during reset.
- R10: X is set from `off_sel_i` on the rising edge of `rst_ni`: code 0 gives 16, code 1 gives 12, code 2 gives 8 and code 3 gives 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low; its rising edge samples the offset select |
| off_sel_i | input | 2 | Offset select code |
| wr_cs_ni | input | 1 | Write chip select, active low |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | 36 | Write data |
| full_no | output | 1 | Full flag, active low, on the write clock |
| almost_full_no | output | 1 | Almost-full flag, active low, on the write clock |
| rd_cs_ni | input | 1 | Read chip select, active low |
| rd_en_i | input | 1 | Read enable |
| rd_data_o | output | 36 | Read data, registered |
| empty_no | output | 1 | Empty flag, active low, on the read clock |
| almost_empty_no | output | 1 | Almost-empty flag, active low, on the read clock |

## Verification
The assertions assume the following about the inputs:
- Both clocks run freely.
- `rst_ni` changes only away from either clock's edges.
- `off_sel_i` is steady around the rising edge of `rst_ni`.

The stimulus meets these conditions as follows:
- Both clocks run at 125 MHz. The read clock lags the write clock by 3 ns, so no two edges ever coincide.
- Reset is asserted and released 2 ns after a write-clock falling edge.
- The select is set while reset is held low.
- All port inputs are driven on falling edges.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Preset threshold: code 0 is the largest, each code step subtracts step_i
  function automatic int unsigned off_value(input logic [1:0] sel_i,
                                            input int unsigned max_i,
                                            input int unsigned step_i);
    return max_i - int'(sel_i) * step_i;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          wclk_i,
  input  logic          wen_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ren_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (wen_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (ren_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int AW = 6,
  localparam int PW = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [PW-1:0] rq2_gray_i,
  input  logic [PW-1:0] thr_i,
  output logic          full_no,
  output logic          afull_no,
  output logic [PW-1:0] wgray_o,
  output logic [AW-1:0] waddr_o,
  output logic          wen_o
);
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wgray_q, rq2_bin, used, free, wbin_nx;
  logic [1:0]    rdy_q;
  logic          full;

  always_comb begin
    rq2_bin[PW-1] = rq2_gray_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) rq2_bin[i] = rq2_bin[i+1] ^ rq2_gray_i[i];
  end

  assign used     = wbin_q - rq2_bin;
  assign free     = PW'(DEPTH) - used;
  assign full     = (used == PW'(DEPTH));
  assign full_no  = rdy_q[1] & ~full;
  assign afull_no = ~rdy_q[0] | (free > thr_i);
  assign wen_o    = push_i & full_no;
  assign wbin_nx  = wbin_q + PW'(1);
  assign waddr_o  = wbin_q[AW-1:0];
  assign wgray_o  = wgray_q;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rdy_q   <= '0;
    end else begin
      rdy_q <= {rdy_q[0], 1'b1};
      if (wen_o) begin
        wbin_q  <= wbin_nx;
        wgray_q <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    used <= PW'(DEPTH)); // R7
  AST_WR_BLOCKED: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (push_i && !full_no) |=> $stable(wgray_q)); // R5
  AST_WGRAY_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1); // R4
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int AW = 6,
  localparam int PW = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic [PW-1:0] wq2_gray_i,
  input  logic [PW-1:0] thr_i,
  output logic          empty_no,
  output logic          aempty_no,
  output logic [PW-1:0] rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          ren_o
);
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin_q, rgray_q, wq2_bin, cnt, rbin_nx;
  logic          rdy_q;

  always_comb begin
    wq2_bin[PW-1] = wq2_gray_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) wq2_bin[i] = wq2_bin[i+1] ^ wq2_gray_i[i];
  end

  assign cnt       = wq2_bin - rbin_q;
  assign empty_no  = (rgray_q != wq2_gray_i);
  assign aempty_no = rdy_q & (cnt > thr_i);
  assign ren_o     = pop_i & empty_no;
  assign rbin_nx   = rbin_q + PW'(1);
  assign raddr_o   = rbin_q[AW-1:0];
  assign rgray_o   = rgray_q;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (ren_o) begin
        rbin_q  <= rbin_nx;
        rgray_q <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    cnt <= PW'(DEPTH)); // R6
  AST_RD_BLOCKED: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (pop_i && !empty_no) |=> $stable(rgray_q)); // R6
  AST_RGRAY_STEP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1); // R4
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DW       = 36,
  parameter int AW       = 6,
  parameter int OFF_MAX  = 16,
  parameter int OFF_STEP = 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic [1:0]    off_sel_i,
  input  logic          wr_cs_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_no,
  output logic          almost_full_no,
  input  logic          rd_cs_ni,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_no,
  output logic          almost_empty_no
);
  import dcf_pkg::*;

  localparam int PW = AW + 1;

  logic [1:0]    sel_q;
  logic [PW-1:0] thr;
  logic [PW-1:0] wgray, rgray, wq2_gray, rq2_gray;
  logic [AW-1:0] waddr, raddr;
  logic          wen, ren, push, pop;

  // Offset select sampled on reset release
  always_ff @(posedge rst_ni) sel_q <= off_sel_i;

  assign thr  = PW'(off_value(sel_q, OFF_MAX, OFF_STEP));
  assign push = ~wr_cs_ni & wr_en_i;
  assign pop  = ~rd_cs_ni & rd_en_i;

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .push_i(push), .rq2_gray_i(rq2_gray),
    .thr_i(thr), .full_no(full_no), .afull_no(almost_full_no),
    .wgray_o(wgray), .waddr_o(waddr), .wen_o(wen)
  );

  dcf_rd_ctl #(.AW(AW)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .pop_i(pop), .wq2_gray_i(wq2_gray),
    .thr_i(thr), .empty_no(empty_no), .aempty_no(almost_empty_no),
    .rgray_o(rgray), .raddr_o(raddr), .ren_o(ren)
  );

  dcf_sync #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wq2_gray));
  dcf_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rq2_gray));

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i(wclk_i), .wen_i(wen), .waddr_i(waddr), .wdata_i(wr_data_i),
    .rclk_i(rclk_i), .rst_ni(rst_ni), .ren_i(ren), .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );

  AST_RDATA_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !ren |=> $stable(rd_data_o)); // R6
  AST_EMPTY_NO_AEMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !almost_empty_no); // R8
endmodule

// File: tb/dcf_fifo_tb.sv
module dcf_fifo_tb;
  logic        wclk_i = 1'b0, rclk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]  off_sel_i = 2'd0;
  logic        wr_cs_ni = 1'b1, wr_en_i = 1'b0, rd_cs_ni = 1'b1, rd_en_i = 1'b0;
  logic [35:0] wr_data_i = '0;
  logic [35:0] rd_data_o;
  logic        full_no, almost_full_no, empty_no, almost_empty_no;

  dcf_fifo u_dut (.*);

  initial forever #4 wclk_i = ~wclk_i;
  initial begin #3; forever #4 rclk_i = ~rclk_i; end

  int tests = 0, fails = 0;
  bit done = 0;

  // Behavioural reference model
  int wr_total, rd_total, rseen1, rseen2, wseen1, wseen2, wrdy, rrdy, xoff;
  logic [35:0] q[$];
  logic [35:0] exp_data;

  function automatic bit e_full_no();   return wrdy >= 2 && (wr_total - rseen2) != 64; endfunction
  function automatic bit e_afull_no();  return wrdy == 0 || (64 - (wr_total - rseen2)) > xoff; endfunction
  function automatic bit e_empty_no();  return wseen2 != rd_total; endfunction
  function automatic bit e_aempty_no(); return rrdy != 0 && (wseen2 - rd_total) > xoff; endfunction

  always @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_total = 0; rseen1 = 0; rseen2 = 0; wrdy = 0; q.delete();
    end else begin
      if (!wr_cs_ni && wr_en_i && e_full_no()) begin
        q.push_back(wr_data_i);
        wr_total++;
      end
      rseen2 = rseen1; rseen1 = rd_total;
      if (wrdy < 2) wrdy++;
    end
  end

  always @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_total = 0; wseen1 = 0; wseen2 = 0; rrdy = 0; exp_data = '0;
    end else begin
      if (!rd_cs_ni && rd_en_i && e_empty_no()) begin
        exp_data = q.pop_front();
        rd_total++;
      end
      wseen2 = wseen1; wseen1 = wr_total;
      rrdy = 1;
    end
  end

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge wclk_i) if (!done) begin
    chk("R3 R5 R7 full_no", 36'(full_no), 36'(e_full_no()));
    chk("R9 R10 almost_full_no", 36'(almost_full_no), 36'(e_afull_no()));
  end

  always @(negedge rclk_i) if (!done) begin
    chk("R4 empty_no", 36'(empty_no), 36'(e_empty_no()));
    chk("R8 R10 almost_empty_no", 36'(almost_empty_no), 36'(e_aempty_no()));
    chk("R1 R6 rd_data_o", rd_data_o, exp_data);
  end

  task automatic do_reset(input logic [1:0] sel);
    @(negedge wclk_i); #2; rst_ni = 1'b0; off_sel_i = sel;
    @(negedge wclk_i); @(negedge wclk_i);
    chk("R2 reset full_no", 36'(full_no), 36'(0));
    chk("R2 reset empty_no", 36'(empty_no), 36'(0));
    chk("R2 reset almost_empty_no", 36'(almost_empty_no), 36'(0));
    chk("R2 reset rd_data_o", rd_data_o, 36'(0));
    #2; xoff = 16 - 4 * int'(sel); rst_ni = 1'b1;
  endtask

  task automatic wr_drive(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk_i);
      case (mode)
        1: begin wr_cs_ni = 1'b0; wr_en_i = 1'b1; end
        2: begin int r = int'($urandom % 4); wr_cs_ni = (r == 0); wr_en_i = (r != 1); end
        default: begin wr_cs_ni = 1'b1; wr_en_i = 1'b0; end
      endcase
      wr_data_i = 36'({$urandom(), $urandom()});
    end
    @(negedge wclk_i); wr_cs_ni = 1'b1; wr_en_i = 1'b0;
  endtask

  task automatic rd_drive(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk_i);
      case (mode)
        1: begin rd_cs_ni = 1'b0; rd_en_i = 1'b1; end
        2: begin int r = int'($urandom % 4); rd_cs_ni = (r == 0); rd_en_i = (r != 1); end
        default: begin rd_cs_ni = 1'b1; rd_en_i = 1'b0; end
      endcase
    end
    @(negedge rclk_i); rd_cs_ni = 1'b1; rd_en_i = 1'b0;
  endtask

  task automatic phase(input int n, input int wm, input int rm);
    fork
      wr_drive(n, wm);
      rd_drive(n, rm);
    join
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      phase(80, 1, 0);   // fill past full, blocked writes (R5 R7)
      phase(6, 0, 0);
      phase(80, 0, 1);   // drain past empty, blocked reads (R6)
      phase(6, 0, 0);
      phase(300, 2, 2);  // mixed with chip select / enable gating
      phase(200, 1, 2);  // write heavy
      phase(200, 2, 1);  // read heavy
      phase(10, 0, 0);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule